// File: doc/BRIEF.md
# Serial Memory Command Slave

This block is the serial-side front end of a small byte-addressed nonvolatile memory. A host drives an active-low select, a serial clock and a serial data line in SPI mode 0. The block synchronises those three pins into a faster system clock and finds the clock edges there. Each select-low frame begins with an 8-bit command byte. For a read or a write, a 24-bit address follows it. After that the block streams array bytes out, takes data bytes in, or returns a status byte.

Written bytes go into an internal synchronous RAM. Raising the select at the end of a write frame starts a fixed-length commit period, during which a busy flag is set. While busy, the block ignores every command except the status query, so a host polls the flag until it clears. The serial output has a separate enable. The enable is high only while the block is actually shifting read or status data out, and an external pad turns it into a high-impedance output.

Top module: `spi_mem_slave`

## Requirements
- R1: Command bytes and address bytes are sampled MSB first on rising serial-clock edges while select is low. 0x03 selects read, 0x02 selects write and 0x05 selects the status query. Read and write are followed by a 24-bit address, MSB first.
- R2: Only the low ADDR_W bits of the 24-bit address select a location; all higher address bits are ignored.
- R3: Read data is shifted out MSB first. It changes only after falling serial-clock edges, and the first bit is valid before the first rising edge that follows the address.
- R4: Every further 8 clocks of a read frame return the byte at the next address. The address wraps from 2^ADDR_W-1 to 0, and the length of the read is unlimited.
- R5: The serial input has no effect on the returned data while read data is being shifted out.
- R6: The output enable is high only during the data phase of a read or status frame. While the enable is low, the serial output is 0.
- R7: Write data bytes are stored at consecutive addresses from the given address, with the same wrap as reads. A trailing group of fewer than 8 bits is discarded.
- R8: At most PAGE_BYTES bytes are stored per write frame; any further bytes in that frame are dropped.
- R9: Raising select after a write frame that stored at least one byte sets the busy flag for COMMIT_CYCLES system clocks. The status query returns {7'b0, busy}, so the busy flag is in bit 0, and it repeats this byte for every further 8 clocks.
- R10: While busy, any command byte other than 0x05 causes the rest of the frame to be ignored. Such a frame produces no output enable and no RAM write.
- R11: A command byte other than 0x02, 0x03 or 0x05 causes the rest of the frame to be ignored: no output enable, no write and no commit.
- R12: After reset the output enable is 0, the serial output is 0 and the busy flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | High while so carries read or status data |

## Verification
The main read and write paths are exercised with a table of single-byte locations. Each location is read back through an address whose upper bits are filled with junk, which separates correct address truncation and bit ordering from a design that uses the wrong bits. Multi-byte bursts that cross the top of the array separate true wraparound from plain incrementing. Reads made while the input line is held high, and reads made while it is held low, show that the input is ignored during output. Write frames are sent with a trailing partial byte, with more bytes than a page, and while busy, and frames carry unknown command bytes; in each case the read-back values and the enable show whether the extra stimulus was correctly dropped.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    S_OPC, S_ADDR, S_RDATA, S_WDATA, S_SDATA, S_IGNORE
  } frame_state_t;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h05;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta    <= RST_VAL[g];
        dout[g] <= RST_VAL[g];
      end else begin
        meta    <= din[g];
        dout[g] <= meta;
      end
    end
  end
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_commit_timer.sv
module spi_commit_timer #(
  parameter int COMMIT_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(COMMIT_CYCLES - 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start && !busy) begin
      cnt  <= LOAD;
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  assert_start_sets_busy_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              commit_start,
  output logic              so,
  output logic              so_oe
);
  localparam int CW  = $clog2(PAGE_BYTES + 1);
  localparam logic [CW-1:0] PAGE_LIM = CW'(PAGE_BYTES);
  localparam int SHW = (ADDR_W > 8) ? ADDR_W : 8;

  frame_state_t    state;
  logic [4:0]      bcnt;
  logic [SHW-2:0]  in_sh;
  logic [SHW-1:0]  sh_next;
  logic [7:0]      out_sh;
  logic [7:0]      src_byte;
  logic            kind_wr;
  logic [CW-1:0]   wr_cnt;
  logic            sck_d, cs_d;
  logic            sck_rise, sck_fall, cs_rise, data_out;

  assign sh_next  = {in_sh, si_s};
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign data_out = (state == S_RDATA) || (state == S_SDATA);

  always_comb src_byte = (state == S_RDATA) ? rd_data : {7'b0, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_OPC;
      bcnt         <= '0;
      in_sh        <= '0;
      out_sh       <= '0;
      addr         <= '0;
      kind_wr      <= 1'b0;
      wr_cnt       <= '0;
      wr_en        <= 1'b0;
      wr_data      <= '0;
      commit_start <= 1'b0;
      so           <= 1'b0;
      so_oe        <= 1'b0;
      sck_d        <= 1'b0;
      cs_d         <= 1'b1;
    end else begin
      sck_d        <= sck_s;
      cs_d         <= cs_s;
      wr_en        <= 1'b0;
      commit_start <= 1'b0;
      so_oe        <= data_out && !cs_s;
      if (cs_s) begin
        state  <= S_OPC;
        bcnt   <= '0;
        so     <= 1'b0;
        wr_cnt <= '0;
        if (cs_rise && wr_cnt != '0) commit_start <= 1'b1;
      end else begin
        if (wr_en) addr <= addr + 1'b1;
        if (sck_rise) begin
          in_sh <= sh_next[SHW-2:0];
          case (state)
            S_OPC: begin
              if (bcnt == 5'd7) begin
                bcnt <= '0;
                if (busy && sh_next[7:0] != OP_STATUS) state <= S_IGNORE;
                else begin
                  case (sh_next[7:0])
                    OP_READ:   begin state <= S_ADDR; kind_wr <= 1'b0; end
                    OP_WRITE:  begin state <= S_ADDR; kind_wr <= 1'b1; end
                    OP_STATUS: state <= S_SDATA;
                    default:   state <= S_IGNORE;
                  endcase
                end
              end else bcnt <= bcnt + 5'd1;
            end
            S_ADDR: begin
              if (bcnt == 5'd23) begin
                bcnt  <= '0;
                addr  <= sh_next[ADDR_W-1:0];
                state <= kind_wr ? S_WDATA : S_RDATA;
              end else bcnt <= bcnt + 5'd1;
            end
            S_RDATA, S_SDATA: bcnt <= (bcnt == 5'd7) ? 5'd0 : bcnt + 5'd1;
            S_WDATA: begin
              if (bcnt == 5'd7) begin
                bcnt <= '0;
                if (wr_cnt < PAGE_LIM) begin
                  wr_en   <= 1'b1;
                  wr_data <= sh_next[7:0];
                  wr_cnt  <= wr_cnt + 1'b1;
                end
              end else bcnt <= bcnt + 5'd1;
            end
            default: ;
          endcase
        end
        if (sck_fall && data_out) begin
          if (bcnt == 5'd0) begin
            so     <= src_byte[7];
            out_sh <= {src_byte[6:0], 1'b0};
            if (state == S_RDATA) addr <= addr + 1'b1;
          end else begin
            so     <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assert_ignore_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_IGNORE && !cs_s) |=> state == S_IGNORE);

  assert_busy_rejects_R10: assert property (@(posedge clk) disable iff (rst)
    (!cs_s && sck_rise && state == S_OPC && bcnt == 5'd7 && busy &&
     sh_next[7:0] != OP_STATUS) |=> state == S_IGNORE);

  assert_idle_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (!so_oe && !so));

  assert_addr_holds_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_s && sck_rise && state == S_RDATA) |=> $stable(addr));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W        = 10,
  parameter int PAGE_BYTES    = 256,
  parameter int COMMIT_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  logic [2:0]        pins_s;
  logic              busy, wr_en, commit_start;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wr_data, rd_data;

  spi_pin_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .din({cs_n, sck, si}), .dout(pins_s)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .cs_s(pins_s[2]), .sck_s(pins_s[1]), .si_s(pins_s[0]),
    .busy(busy), .rd_data(rd_data), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .commit_start(commit_start), .so(so), .so_oe(so_oe)
  );

  spi_mem_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .addr(addr), .wdata(wr_data), .rdata(rd_data)
  );

  spi_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(commit_start), .busy(busy)
  );

  assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);
endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int H = 6;
  localparam int COMMIT = 4000;
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    32'h000010_A5, 32'h000011_3C, 32'h0003FE_81, 32'h000200_7E,
    32'h000155_AA, 32'h0000FF_01, 32'h000100_FE, 32'h000020_00
  };

  logic clk = 0, rst = 1, cs_n = 1, sck = 0, si = 0;
  logic so, so_oe;
  int checks = 0, errors = 0;
  logic oe_all, oe_any, hdr_oe;
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;

  spi_mem_slave #(.ADDR_W(10), .PAGE_BYTES(256), .COMMIT_CYCLES(COMMIT)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      si = tx[i];
      repeat (H) @(negedge clk);
      sck = 1;
      rx[i] = so;
      oe_all &= so_oe;
      oe_any |= so_oe;
      repeat (H) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_up();
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a, input bit with_addr);
    logic [7:0] d;
    oe_any = 0; oe_all = 1;
    xbits(op, 8, d);
    if (with_addr) begin
      xbits(a[23:16], 8, d);
      xbits(a[15:8], 8, d);
      xbits(a[7:0], 8, d);
    end
    hdr_oe = oe_any;
    oe_any = 0; oe_all = 1;
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int n,
                         input logic [7:0] fill);
    logic [7:0] d;
    cs_lo();
    header(op, a, op != 8'h05);
    for (int k = 0; k < n; k++) begin
      xbits(fill, 8, d);
      rbuf[k] = d;
    end
    cs_up();
  endtask

  task automatic do_write(input logic [23:0] a, input int n, input logic [7:0] base,
                          input int tail_bits);
    logic [7:0] d;
    cs_lo();
    header(8'h02, a, 1'b1);
    for (int k = 0; k < n; k++) xbits(base + 8'(k), 8, d);
    if (tail_bits > 0) xbits(8'hC3, tail_bits, d);
    cs_up();
  endtask

  task automatic wait_commit();
    repeat (COMMIT + 200) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 so_oe after reset", {7'b0, so_oe}, 8'h00);
    chk("R12 so after reset", {7'b0, so}, 8'h00);
    do_read(8'h05, 24'h0, 1, 8'h00);
    chk("R12 busy clear after reset", rbuf[0], 8'h00);

    // R1 R2 R3: table walk, written plainly, read back through aliased address
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][31:8], 1, VEC[i][7:0], 0);
      wait_commit();
    end
    for (int i = 0; i < NV; i++) begin
      do_read(8'h03, VEC[i][31:8] | 24'hA5AC00, 1, 8'h00);
      chk("R1 R2 R3 table read", rbuf[0], VEC[i][7:0]);
    end

    // R4 R7 burst write and read across top of array; R6 enable phases
    do_write(24'h0003FE, 4, 8'h40, 0);
    wait_commit();
    do_read(8'h03, 24'h0003FF, 3, 8'h00);
    chk("R4 burst byte0", rbuf[0], 8'h41);
    chk("R4 R7 wrapped byte1", rbuf[1], 8'h42);
    chk("R7 byte2", rbuf[2], 8'h43);
    chk("R6 enable low in header", {7'b0, hdr_oe}, 8'h00);
    chk("R6 enable high in data", {7'b0, oe_all}, 8'h01);

    // R5 input ignored during read data
    do_read(8'h03, 24'h0003FE, 2, 8'hFF);
    chk("R5 read with si high b0", rbuf[0], 8'h40);
    chk("R5 read with si high b1", rbuf[1], 8'h41);

    // R9 R10 busy behaviour
    do_write(24'h000050, 1, 8'h77, 0);
    do_read(8'h05, 24'h0, 2, 8'h00);
    chk("R9 status busy first", rbuf[0], 8'h01);
    chk("R9 status busy repeat", rbuf[1], 8'h01);
    do_read(8'h03, 24'h000050, 2, 8'h00);
    chk("R10 read rejected while busy", {7'b0, oe_any}, 8'h00);
    do_write(24'h000050, 1, 8'h99, 0);
    wait_commit();
    do_read(8'h05, 24'h0, 1, 8'h00);
    chk("R9 status idle after commit", rbuf[0], 8'h00);
    do_read(8'h03, 24'h000050, 1, 8'h00);
    chk("R10 busy write dropped", rbuf[0], 8'h77);

    // R7 trailing partial byte discarded
    do_write(24'h000061, 1, 8'h11, 0);
    wait_commit();
    do_write(24'h000060, 1, 8'h22, 4);
    wait_commit();
    do_read(8'h03, 24'h000060, 2, 8'h00);
    chk("R7 full byte stored", rbuf[0], 8'h22);
    chk("R7 partial byte discarded", rbuf[1], 8'h11);

    // R8 page limit
    do_write(24'h0001F0, 1, 8'h5A, 0);
    wait_commit();
    do_write(24'h0000F0, 257, 8'h00, 0);
    wait_commit();
    do_read(8'h03, 24'h0001EF, 2, 8'h00);
    chk("R8 last page byte stored", rbuf[0], 8'hFF);
    chk("R8 byte past page dropped", rbuf[1], 8'h5A);

    // R11 unknown command byte
    do_read(8'h9F, 24'h000050, 2, 8'h00);
    chk("R11 unknown op no enable", {7'b0, oe_any | hdr_oe}, 8'h00);
    cs_lo();
    oe_any = 0; oe_all = 1;
    xbits(8'hA7, 8, d);
    xbits(8'h02, 8, d); xbits(8'h00, 8, d); xbits(8'h00, 8, d);
    xbits(8'h50, 8, d); xbits(8'h33, 8, d);
    cs_up();
    do_read(8'h05, 24'h0, 1, 8'h00);
    chk("R11 unknown op no commit", rbuf[0], 8'h00);
    do_read(8'h03, 24'h000050, 1, 8'h00);
    chk("R11 unknown op no write", rbuf[0], 8'h77);
    chk("R6 enable low after frame", {7'b0, so_oe}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule